// File: doc/BRIEF.md
# Piecewise Gamma Curve Interpolator

This block turns an 8-bit pixel code into a 10-bit drive level. It keeps six programmable transfer curves: one for each of red, green and blue, in a positive and a negative drive polarity. Each curve is set by 26 breakpoint values at fixed input codes. The codes are packed densely near black and near white and are sparse in the middle. For a code that falls between two breakpoints, the output is a straight-line blend of the two neighbouring values.

Software loads a curve one byte at a time. It first selects the curve with a one-cycle load strobe and then writes 52 bytes, which are the 26 breakpoints as pairs. A curve only replaces the one in use after its last byte arrives, and only if every value rises strictly above the one before it. A curve that fails this check is thrown away and raises a sticky error flag. Pixels flow through a two-stage pipeline with a valid/ready handshake on both sides.

Top module: `gamma_interp`

## Requirements
- R1: After reset, `out_valid` and `curve_err` are 0 and `pix_ready` is 1. Every curve holds value 4*p at each breakpoint code p, so each curve returns 4*code for every code.
- R2: The breakpoint codes are 0, 1, 3, 5, 7, 11, 15, 23, 31, 47, 63, 95, 127, 128, 160, 192, 208, 224, 232, 240, 244, 248, 250, 252, 254, 255. A pixel whose code equals breakpoint k returns the stored value k exactly.
- R3: For a code c with p_k < c < p_(k+1), the output is v_k + floor((v_(k+1) - v_k) * (c - p_k) / (p_(k+1) - p_k)).
- R4: A load is a `cfg_load` strobe with curve index `cfg_curve`, followed by 52 `cfg_wr` bytes. The bytes go breakpoint 0 first, each breakpoint as its high byte and then its low byte. Value bits 9:8 are high-byte bits 1:0. High-byte bits 7:2 are ignored.
- R5: Curve index = 2*colour + polarity. `pix_chan` gives the colour: 0 red, 1 green, 2 blue, and 3 also selects blue. `pix_neg` = 1 selects the negative curve. So the indices are 0 R+, 1 R-, 2 G+, 3 G-, 4 B+, 5 B-.
- R6: A curve being loaded keeps its old values until the 52nd byte. A new `cfg_load` strobe abandons a partial load and starts counting from byte 0.
- R7: If any loaded value is less than or equal to the value before it, the load is discarded, the old curve stays, and `curve_err` is set.
- R8: A pixel accepted at one clock edge appears on `out_valid`/`out_level` after the second edge, provided `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output holds steady. `pix_ready` goes low only under that stall.
- R9: `cfg_wr` bytes written outside a load have no effect. A load strobe naming index 6 or 7 starts no load, and the bytes that follow it have no effect.
- R10: Once set, `curve_err` stays high until reset, including after later good loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Start a curve load |
| cfg_curve | input | 3 | Curve index for the load |
| cfg_wr | input | 1 | Curve byte strobe |
| cfg_byte | input | 8 | Curve byte |
| curve_err | output | 1 | Sticky flag: a non-rising curve was rejected |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel accepted when high with pix_valid |
| pix_code | input | 8 | Pixel code |
| pix_chan | input | 2 | Colour select |
| pix_neg | input | 1 | Polarity select |
| out_valid | output | 1 | Drive level available |
| out_ready | input | 1 | Consumer takes the level |
| out_level | output | 10 | Interpolated drive level |

## Verification
The assertions assume the sink's `out_ready` is a free-running input and that reset holds `pix_valid` low. The bench keeps to this by driving every input at the falling edge. The latency check also assumes that a pixel accepted while the output is stalled is not expected two cycles later. The bench only exercises the fixed latency with `out_ready` held high, and it exercises the stall separately. Curve loads in the bench never overlap pixel traffic whose expected value depends on the curve being replaced.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int PIX_W  = 8;
    localparam int VAL_W  = 10;
    localparam int NPTS   = 26;
    localparam int NCURVE = 6;
    localparam int SEL_W  = 3;
    localparam int SH_W   = 3;

    // input code of breakpoint i
    function automatic int bp_pos(input int i);
        case (i)
            0: return 0;     1: return 1;     2: return 3;     3: return 5;
            4: return 7;     5: return 11;    6: return 15;    7: return 23;
            8: return 31;    9: return 47;    10: return 63;   11: return 95;
            12: return 127;  13: return 128;  14: return 160;  15: return 192;
            16: return 208;  17: return 224;  18: return 232;  19: return 240;
            20: return 244;  21: return 248;  22: return 250;  23: return 252;
            24: return 254;  default: return 255;
        endcase
    endfunction

    // every segment spans a power of two codes; return its log2
    function automatic int seg_log2(input int i);
        int span;
        int r;
        span = bp_pos(i + 1) - bp_pos(i);
        r = 0;
        for (int j = 0; j < 8; j++)
            if ((1 << j) == span) r = j;
        return r;
    endfunction
endpackage

// File: rtl/gamma_curve_store.sv
module gamma_curve_store
    import gamma_pkg::*;
#(
    parameter int NP = NPTS,
    parameter int VW = VAL_W,
    parameter int NC = NCURVE,
    parameter int SW = SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load,
    input  logic [SW-1:0]          cfg_curve,
    input  logic                   cfg_wr,
    input  logic [7:0]             cfg_byte,
    input  logic [SW-1:0]          rd_curve,
    input  logic [$clog2(NP)-1:0]  rd_idx,
    output logic [VW-1:0]          rd_lo,
    output logic [VW-1:0]          rd_hi,
    output logic                   curve_err
);
    localparam int NBYTES = 2 * NP;
    localparam int CNT_W  = $clog2(NBYTES + 1);
    localparam int IDX_W  = $clog2(NP);
    localparam int HI_W   = VW - 8;

    typedef struct packed {
        logic                           active;
        logic [SW-1:0]                  sel;
        logic [CNT_W-1:0]               cnt;
        logic [HI_W-1:0]                hi;
        logic [VW-1:0]                  prev;
        logic                           ok;
        logic                           err;
        logic [NP-1:0][VW-1:0]          stage;
        logic [NC-1:0][NP-1:0][VW-1:0]  curves;
    } st_t;

    function automatic st_t init_state();
        st_t s;
        s = '0;
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < NP; i++)
                s.curves[c][i] = VW'(bp_pos(i) << (VW - 8));
        return s;
    endfunction

    localparam st_t RST = init_state();

    st_t st_q, st_d;
    logic [VW-1:0]    val;
    logic [IDX_W-1:0] pt;

    always_comb begin
        st_d = st_q;
        val  = {st_q.hi, cfg_byte};
        pt   = IDX_W'(st_q.cnt >> 1);
        if (cfg_load) begin
            st_d.active = (int'(cfg_curve) < NC);
            st_d.sel    = cfg_curve;
            st_d.cnt    = '0;
            st_d.ok     = 1'b1;
        end else if (cfg_wr && st_q.active) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (!st_q.cnt[0]) begin
                st_d.hi = cfg_byte[HI_W-1:0];
            end else begin
                st_d.stage[pt] = val;
                st_d.prev      = val;
                if (pt != '0 && val <= st_q.prev) st_d.ok = 1'b0;
                if (int'(st_q.cnt) == NBYTES - 1) begin
                    st_d.active = 1'b0;
                    if (st_d.ok) st_d.curves[st_q.sel] = st_d.stage;
                    else         st_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign rd_lo     = st_q.curves[rd_curve][rd_idx];
    assign rd_hi     = st_q.curves[rd_curve][rd_idx + 1'b1];
    assign curve_err = st_q.err;
endmodule

// File: rtl/gamma_seg_find.sv
module gamma_seg_find
    import gamma_pkg::*;
#(
    parameter int NP = NPTS,
    parameter int PW = PIX_W
) (
    input  logic [PW-1:0]          code,
    output logic [$clog2(NP)-1:0]  seg,
    output logic [PW-1:0]          dx,
    output logic [SH_W-1:0]        sh
);
    localparam int IDX_W = $clog2(NP);

    always_comb begin
        seg = '0;
        dx  = code;
        sh  = SH_W'(seg_log2(0));
        for (int i = 1; i < NP - 1; i++) begin
            if (code >= PW'(bp_pos(i))) begin
                seg = IDX_W'(i);
                dx  = code - PW'(bp_pos(i));
                sh  = SH_W'(seg_log2(i));
            end
        end
    end
endmodule

// File: rtl/gamma_pipe.sv
module gamma_pipe
    import gamma_pkg::*;
#(
    parameter int NP = NPTS,
    parameter int PW = PIX_W,
    parameter int VW = VAL_W,
    parameter int SW = SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [SW-1:0]          in_curve,
    input  logic [$clog2(NP)-1:0]  in_seg,
    input  logic [PW-1:0]          in_dx,
    input  logic [SH_W-1:0]        in_sh,
    output logic [SW-1:0]          rd_curve,
    output logic [$clog2(NP)-1:0]  rd_idx,
    input  logic [VW-1:0]          rd_lo,
    input  logic [VW-1:0]          rd_hi,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [VW-1:0]          out_level
);
    localparam int PROD_W = VW + PW;

    typedef struct packed {
        logic            v1;
        logic [VW-1:0]   lo;
        logic [VW-1:0]   hi;
        logic [PW-1:0]   dx;
        logic [SH_W-1:0] sh;
        logic            v2;
        logic [VW-1:0]   level;
    } pp_t;

    pp_t pp_q, pp_d;
    logic adv1, adv2;
    logic [VW-1:0]     diff;
    logic [PROD_W-1:0] prod;

    always_comb begin
        pp_d = pp_q;
        adv2 = !pp_q.v2 || out_ready;
        adv1 = !pp_q.v1 || adv2;
        diff = pp_q.hi - pp_q.lo;
        prod = PROD_W'(diff) * PROD_W'(pp_q.dx);
        if (adv2) begin
            pp_d.v2    = pp_q.v1;
            pp_d.level = pp_q.lo + VW'(prod >> pp_q.sh);
        end
        if (adv1) begin
            pp_d.v1 = in_valid;
            pp_d.lo = rd_lo;
            pp_d.hi = rd_hi;
            pp_d.dx = in_dx;
            pp_d.sh = in_sh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign in_ready  = adv1;
    assign rd_curve  = in_curve;
    assign rd_idx    = in_seg;
    assign out_valid = pp_q.v2;
    assign out_level = pp_q.level;
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
    import gamma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [SEL_W-1:0] cfg_curve,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_byte,
    output logic             curve_err,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [PIX_W-1:0] pix_code,
    input  logic [1:0]       pix_chan,
    input  logic             pix_neg,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VAL_W-1:0] out_level
);
    localparam int IDX_W = $clog2(NPTS);

    logic [1:0]       colour;
    logic [SEL_W-1:0] curve_sel, rd_curve;
    logic [IDX_W-1:0] seg, rd_idx;
    logic [PIX_W-1:0] dx;
    logic [SH_W-1:0]  sh;
    logic [VAL_W-1:0] rd_lo, rd_hi;

    assign colour    = (pix_chan == 2'd3) ? 2'd2 : pix_chan;
    assign curve_sel = SEL_W'({colour, pix_neg});

    gamma_curve_store u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_load(cfg_load), .cfg_curve(cfg_curve),
        .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
        .rd_curve(rd_curve), .rd_idx(rd_idx),
        .rd_lo(rd_lo), .rd_hi(rd_hi),
        .curve_err(curve_err)
    );

    gamma_seg_find u_seg (
        .code(pix_code), .seg(seg), .dx(dx), .sh(sh)
    );

    gamma_pipe u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pix_valid), .in_ready(pix_ready),
        .in_curve(curve_sel), .in_seg(seg), .in_dx(dx), .in_sh(sh),
        .rd_curve(rd_curve), .rd_idx(rd_idx),
        .rd_lo(rd_lo), .rd_hi(rd_hi),
        .out_valid(out_valid), .out_ready(out_ready), .out_level(out_level)
    );
endmodule

// File: rtl/gamma_interp_chk.sv
module gamma_interp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       curve_err,
    input logic       pix_valid,
    input logic       pix_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [9:0] out_level
);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_level)));

    // R8
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ready |-> (out_valid && !out_ready));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pix_valid && pix_ready, 2) && $past(out_ready)) |-> out_valid);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        curve_err |=> curve_err);
endmodule

bind gamma_interp gamma_interp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .curve_err(curve_err),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_level(out_level)
);

// File: tb/sim_gamma_interp.sv
module sim_gamma_interp;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_load, cfg_wr;
    logic [2:0] cfg_curve;
    logic [7:0] cfg_byte;
    logic       curve_err;
    logic       pix_valid, pix_ready, pix_neg;
    logic [7:0] pix_code;
    logic [1:0] pix_chan;
    logic       out_valid, out_ready;
    logic [9:0] out_level;

    int nchk = 0;
    int nfail = 0;
    int pos [26];
    int model [6][26];
    int newv [26];
    bit done = 0;

    always #5 clk = ~clk;

    gamma_interp u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_curve(cfg_curve),
        .cfg_wr(cfg_wr), .cfg_byte(cfg_byte), .curve_err(curve_err),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_code(pix_code),
        .pix_chan(pix_chan), .pix_neg(pix_neg), .out_valid(out_valid),
        .out_ready(out_ready), .out_level(out_level)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_lvl(input int cv, input int code);
        int k = 0;
        for (int i = 1; i < 25; i++) if (code >= pos[i]) k = i;
        return model[cv][k] + ((model[cv][k+1] - model[cv][k]) * (code - pos[k]))
               / (pos[k+1] - pos[k]);
    endfunction

    task automatic px(input int ch, input int ng, input int code, input string req);
        int cv = ((ch == 3) ? 2 : ch) * 2 + ng;
        @(negedge clk);
        pix_valid = 1; pix_chan = 2'(ch); pix_neg = 1'(ng); pix_code = 8'(code);
        @(negedge clk);
        pix_valid = 0;
        check({req, " one-cycle gap"}, int'(out_valid), 0);
        @(negedge clk);
        check({req, " valid"}, int'(out_valid), 1);
        check(req, int'(out_level), expect_lvl(cv, code));
    endtask

    // loads newv into curve idx, writing only nbytes bytes
    task automatic load(input int idx, input int nbytes);
        bit rising = 1;
        @(negedge clk);
        cfg_load = 1; cfg_curve = 3'(idx);
        @(negedge clk);
        cfg_load = 0;
        for (int b = 0; b < nbytes; b++) begin
            cfg_wr = 1;
            if (b % 2 == 0) cfg_byte = 8'((newv[b/2] >> 8) | 8'hA8);
            else            cfg_byte = 8'(newv[b/2]);
            @(negedge clk);
        end
        cfg_wr = 0;
        for (int i = 1; i < 26; i++) if (newv[i] <= newv[i-1]) rising = 0;
        if (nbytes == 52 && idx < 6 && rising)
            for (int i = 0; i < 26; i++) model[idx][i] = newv[i];
    endtask

    task automatic t_reset();
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 curve_err", int'(curve_err), 0);
        check("R1 pix_ready", int'(pix_ready), 1);
        px(0, 0, 0, "R1 default code 0");
        px(1, 1, 2, "R1 R3 default code 2");
        px(2, 0, 100, "R1 R3 default code 100");
        px(0, 1, 127, "R1 default code 127");
        px(1, 0, 200, "R1 R3 default code 200");
        px(2, 1, 255, "R1 default code 255");
    endtask

    task automatic t_custom();
        for (int i = 0; i < 26; i++) newv[i] = i * i + 3 * i + 7;
        load(1, 52);
        for (int i = 0; i < 26; i++) px(0, 1, pos[i], "R2 R4 breakpoint hit");
        px(0, 1, 2, "R3 mid 2");
        px(0, 1, 9, "R3 mid 9");
        px(0, 1, 40, "R3 mid 40");
        px(0, 1, 100, "R3 mid 100");
        px(0, 1, 150, "R3 mid 150");
        px(0, 1, 251, "R3 mid 251");
        px(0, 0, 100, "R5 red positive untouched");
        px(1, 1, 100, "R5 green negative untouched");
    endtask

    task automatic t_select();
        for (int i = 0; i < 26; i++) newv[i] = 20 * i + 100;
        load(4, 52);
        px(2, 0, 128, "R5 blue positive");
        px(3, 0, 130, "R5 chan 3 is blue");
        px(3, 1, 130, "R5 blue negative untouched");
    endtask

    task automatic t_partial();
        for (int i = 0; i < 26; i++) newv[i] = 30 * i + 5;
        load(2, 30);
        px(1, 0, 127, "R6 partial load keeps old");
        load(2, 52);
        px(1, 0, 127, "R6 restarted load applied");
        px(1, 0, 70, "R6 restarted load interp");
    endtask

    task automatic t_bad();
        for (int i = 0; i < 26; i++) newv[i] = 10 * i + 50;
        newv[10] = newv[9];
        load(0, 52);
        check("R7 err set", int'(curve_err), 1);
        px(0, 0, 63, "R7 old curve kept");
        for (int i = 0; i < 26; i++) newv[i] = 35 * i + 1;
        load(3, 52);
        check("R10 err sticky", int'(curve_err), 1);
        px(1, 1, 63, "R10 good load after error applies");
    endtask

    task automatic t_ignore();
        for (int b = 0; b < 10; b++) begin
            @(negedge clk);
            cfg_wr = 1; cfg_byte = 8'h00;
        end
        @(negedge clk);
        cfg_wr = 0;
        px(1, 1, 47, "R9 stray bytes ignored");
        for (int i = 0; i < 26; i++) newv[i] = 2 * i + 9;
        load(6, 52);
        px(0, 0, 47, "R9 index 6 red+");
        px(1, 1, 47, "R9 index 6 green-");
        px(2, 1, 47, "R9 index 6 blue-");
        load(7, 52);
        px(2, 0, 47, "R9 index 7 blue+");
    endtask

    task automatic t_stall();
        int ea, eb;
        ea = expect_lvl(0, 30);
        eb = expect_lvl(0, 220);
        @(negedge clk);
        out_ready = 0;
        pix_valid = 1; pix_chan = 0; pix_neg = 0; pix_code = 8'd30;
        @(negedge clk);
        pix_code = 8'd220;
        @(negedge clk);
        pix_valid = 0;
        for (int c = 0; c < 3; c++) begin
            check("R8 stalled valid", int'(out_valid), 1);
            check("R8 stalled level", int'(out_level), ea);
            check("R8 ready low in stall", int'(pix_ready), 0);
            @(negedge clk);
        end
        out_ready = 1;
        @(negedge clk);
        check("R8 second after release", int'(out_level), eb);
        check("R8 second valid", int'(out_valid), 1);
        @(negedge clk);
        check("R8 drained", int'(out_valid), 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        pos = '{0, 1, 3, 5, 7, 11, 15, 23, 31, 47, 63, 95, 127, 128, 160, 192,
                208, 224, 232, 240, 244, 248, 250, 252, 254, 255};
        for (int c = 0; c < 6; c++)
            for (int i = 0; i < 26; i++) model[c][i] = 4 * pos[i];
        rst_n = 0; cfg_load = 0; cfg_curve = 0; cfg_wr = 0; cfg_byte = 0;
        pix_valid = 0; pix_code = 0; pix_chan = 0; pix_neg = 0; out_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_custom();
        t_select();
        t_partial();
        t_bad();
        t_ignore();
        t_stall();
        finish_up();
    end
endmodule